// File: doc/BRIEF.md
# Block-Partitioned Clock-Crossing Stream Buffer

This block moves a stream of words from a producer clock domain to a consumer clock domain through an internal dual-port memory. The memory is treated as a ring of equal blocks, and the block size is a power of two chosen by a control field. Each time the producer fills a block, the consumer domain sees a single-cycle event and a sticky tide flag. These tell the consumer that the block just completed is ready to be read.

The producer's write location is carried into the consumer domain in Gray code and shown there in binary, next to the consumer's own read location. From these two the block works out how many whole blocks the reader is behind. That count stays right even when the consumer missed one or more events. The buffer does not guard against overwriting unread data. Instead, the consumer can ask for the producer to be held off, and that request is synchronised into the producer domain and returned there as a stall.

Top module: `blk_xfer_buf`

## Requirements
- R1: After both resets, `wr_addr_rd`, `rd_addr`, `lag_blks`, `rd_data`, `blk_event`, `tide` and `wr_stall` are all zero.
- R2: Every write accepted while `wr_en` is high and `wr_stall` is low stores `wr_data` at the current write location, and the write location then advances by one. Each consumer cycle with `rd_en` high reads the word at `rd_addr` onto `rd_data` at the next `rclk` edge, then advances `rd_addr` by one, so words come out in the order they were written.
- R3: An accepted write that leaves the write location at a multiple of 2^`blk_lg` produces exactly one single-cycle `blk_event` pulse in the consumer domain. Any other write produces none.
- R4: `tide` sets in the cycle after a `blk_event` pulse. It stays set until `tide_clr` is high in a cycle without a new event.
- R5: A few cycles after the last write, `wr_addr_rd` equals the producer's write location in plain binary. The location crosses domains as a Gray code, and the Gray code changes by at most one bit per producer cycle.
- R6: `lag_blks` equals ((`wr_addr_rd` >> `blk_lg`) - (`rd_addr` >> `blk_lg`)) modulo 2^(ADDR_W - `blk_lg`).
- R7: While `stall_req` is high, `wr_stall` goes high after two producer-clock flops, and writes offered during the stall change neither the memory nor the write location.
- R8: Both locations wrap from 2^ADDR_W - 1 to 0, and the lag stays correct across the wrap.
- R9: `blk_lg` must lie between 0 and ADDR_W. It may change only while both resets are held or while the buffer is empty. A new value applied under reset sets the event spacing to the new block size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| wrst | input | 1 | Producer synchronous reset, active high |
| wr_en | input | 1 | Producer offers a word |
| wr_data | input | DATA_W | Word to store |
| wr_stall | output | 1 | Stall seen by the producer; writes are dropped while high |
| rclk | input | 1 | Consumer clock |
| rrst | input | 1 | Consumer synchronous reset, active high |
| blk_lg | input | LG_W | log2 of the block size in words |
| rd_en | input | 1 | Consumer reads one word |
| rd_data | output | DATA_W | Word read, valid one cycle after rd_en |
| rd_addr | output | ADDR_W | Consumer read location |
| wr_addr_rd | output | ADDR_W | Producer write location as seen by the consumer |
| lag_blks | output | ADDR_W | Whole blocks by which reading trails writing |
| blk_event | output | 1 | One-cycle pulse per block boundary crossed |
| tide | output | 1 | Sticky flag, set by an event |
| tide_clr | input | 1 | Clears tide |
| stall_req | input | 1 | Consumer request to hold off the producer |

## Verification
The bench builds the block with DATA_W = 16 and ADDR_W = 6. A 64-word ring is small enough that a few dozen writes take the pointers through a full wrap, where the lag has to be computed modulo the block count. The run starts with `blk_lg` = 3, which gives eight blocks of eight words and makes the lag reach 6 after the wrap. Both domains are then reset with `blk_lg` = 4 to show that the event spacing follows the new block size. The producer and consumer run at different clock periods, so the Gray pointer and the event toggle really do cross between unrelated edges.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;

    localparam int PTR_MAX = 17;

    typedef logic [PTR_MAX-1:0] ptr_t;

    typedef struct packed {
        logic pulse;
        logic flag;
    } evt_state_t;

    function automatic ptr_t to_gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t from_gray(ptr_t g);
        ptr_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic ptr_t low_mask(int unsigned lg);
        ptr_t m;
        for (int i = 0; i < PTR_MAX; i++) begin
            m[i] = (i < lg);
        end
        return m;
    endfunction

endpackage

// File: rtl/xbuf_sync.sv
module xbuf_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xbuf_mem.sv
module xbuf_mem #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst)    rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/xbuf_wside.sv
module xbuf_wside
    import xbuf_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int LG_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              stall,
    input  logic [LG_W-1:0]   blk_lg,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] gray_q,
    output logic              tgl_q
);
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] nxt;
    logic [ADDR_W-1:0] blk_mask;
    logic              accept;
    logic              crossing;
    ptr_t              mask_full;
    ptr_t              gray_full;

    assign accept    = wr_en && !stall;
    assign nxt       = wptr + 1'b1;
    assign mask_full = low_mask(int'(blk_lg));
    assign blk_mask  = mask_full[ADDR_W-1:0];
    assign crossing  = accept && ((nxt & blk_mask) == '0);
    assign gray_full = to_gray(ptr_t'(accept ? nxt : wptr));

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr   <= '0;
            gray_q <= '0;
            tgl_q  <= 1'b0;
        end else begin
            if (accept)   wptr  <= nxt;
            if (crossing) tgl_q <= ~tgl_q;
            gray_q <= gray_full[ADDR_W-1:0];
        end
    end

    assign mem_we   = accept;
    assign mem_addr = wptr;

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(wptr));

    p_gray_one_bit_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(gray_q ^ $past(gray_q)) <= 1);

    p_boundary_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        crossing |=> (tgl_q != $past(tgl_q)));

    p_no_cross_no_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        !crossing |=> $stable(tgl_q));
endmodule

// File: rtl/xbuf_rside.sv
module xbuf_rside
    import xbuf_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int LG_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              tide_clr,
    input  logic [LG_W-1:0]   blk_lg,
    input  logic [ADDR_W-1:0] wgray_s,
    input  logic              tgl_s,
    output logic [ADDR_W-1:0] rptr,
    output logic [ADDR_W-1:0] wbin,
    output logic [ADDR_W-1:0] lag,
    output evt_state_t        evt
);
    logic              tgl_d;
    logic              tide_q;
    logic              pulse;
    ptr_t              bin_full;
    logic [ADDR_W-1:0] wblk;
    logic [ADDR_W-1:0] rblk;
    logic [ADDR_W-1:0] cnt_mask;

    assign bin_full = from_gray(ptr_t'(wgray_s));
    assign wbin     = bin_full[ADDR_W-1:0];
    assign pulse    = tgl_s ^ tgl_d;

    assign wblk     = wbin >> blk_lg;
    assign rblk     = rptr >> blk_lg;
    assign cnt_mask = {ADDR_W{1'b1}} >> blk_lg;
    assign lag      = (wblk - rblk) & cnt_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr   <= '0;
            tgl_d  <= 1'b0;
            tide_q <= 1'b0;
        end else begin
            tgl_d <= tgl_s;
            if (rd_en) rptr <= rptr + 1'b1;
            if (pulse)         tide_q <= 1'b1;
            else if (tide_clr) tide_q <= 1'b0;
        end
    end

    assign evt.pulse = pulse;
    assign evt.flag  = tide_q;

    p_event_sets_tide_r4: assert property (@(posedge clk) disable iff (rst)
        pulse |=> tide_q);

    p_tide_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (tide_q && !tide_clr) |=> tide_q);

    p_rptr_step_r8: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rptr == ADDR_W'($past(rptr) + 1'b1)));

    p_rptr_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rptr));
endmodule

// File: rtl/blk_xfer_buf.sv
module blk_xfer_buf
    import xbuf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    localparam int LG_W  = $clog2(ADDR_W + 1)
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_stall,
    input  logic              rclk,
    input  logic              rrst,
    input  logic [LG_W-1:0]   blk_lg,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr_rd,
    output logic [ADDR_W-1:0] lag_blks,
    output logic              blk_event,
    output logic              tide,
    input  logic              tide_clr,
    input  logic              stall_req
);
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [ADDR_W-1:0] wgray;
    logic [ADDR_W-1:0] wgray_s;
    logic              tgl;
    logic              tgl_s;
    evt_state_t        evt;

    xbuf_sync #(.WIDTH(1), .STAGES(2)) u_stall_sync (
        .clk(wclk), .rst(wrst), .d(stall_req), .q(wr_stall)
    );

    xbuf_wside #(.ADDR_W(ADDR_W)) u_wside (
        .clk(wclk), .rst(wrst), .wr_en(wr_en), .stall(wr_stall),
        .blk_lg(blk_lg), .mem_we(mem_we), .mem_addr(mem_addr),
        .gray_q(wgray), .tgl_q(tgl)
    );

    xbuf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(wclk), .we(mem_we), .waddr(mem_addr), .wdata(wr_data),
        .rclk(rclk), .rrst(rrst), .re(rd_en), .raddr(rd_addr),
        .rdata(rd_data)
    );

    xbuf_sync #(.WIDTH(ADDR_W), .STAGES(2)) u_ptr_sync (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s)
    );

    xbuf_sync #(.WIDTH(1), .STAGES(2)) u_tgl_sync (
        .clk(rclk), .rst(rrst), .d(tgl), .q(tgl_s)
    );

    xbuf_rside #(.ADDR_W(ADDR_W)) u_rside (
        .clk(rclk), .rst(rrst), .rd_en(rd_en), .tide_clr(tide_clr),
        .blk_lg(blk_lg), .wgray_s(wgray_s), .tgl_s(tgl_s),
        .rptr(rd_addr), .wbin(wr_addr_rd), .lag(lag_blks), .evt(evt)
    );

    assign blk_event = evt.pulse;
    assign tide      = evt.flag;

    initial p_blk_lg_range_r9: assert (ADDR_W <= PTR_MAX - 1);
endmodule

// File: tb/sim_blk_xfer_buf.sv
module sim_blk_xfer_buf;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
    localparam int DW = 16;
    localparam int AW = 6;
    localparam int LW = $clog2(AW + 1);

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wrst = 1'b1, rrst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0, tide_clr = 1'b0, stall_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [LW-1:0] blk_lg = LW'(3);
    logic          wr_stall, blk_event, tide;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] rd_addr, wr_addr_rd, lag_blks;

    int n_checks = 0, n_fail = 0, evt_cnt = 0, evt_base = 0;
    logic [DW-1:0] seq = 16'hA000;
    logic [DW-1:0] exp_q[$];
    logic rd_pend = 1'b0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2)  wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    blk_xfer_buf #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_stall(wr_stall), .rclk(rclk), .rrst(rrst), .blk_lg(blk_lg),
        .rd_en(rd_en), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_addr_rd(wr_addr_rd), .lag_blks(lag_blks), .blk_event(blk_event),
        .tide(tide), .tide_clr(tide_clr), .stall_req(stall_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // event counter
    always @(posedge rclk) if (!rrst && blk_event) evt_cnt++;

    // monitor: compare read data against scoreboard
    always @(posedge rclk) rd_pend <= rd_en && !rrst;
    always @(negedge rclk) begin
        if (rd_pend) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: actual %0h expected none (queue empty)", rd_data);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL R2: actual %0h expected %0h", rd_data, e);
                end
            end
        end
    end

    task automatic write_n(input int n, input bit push);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_en   = 1'b1;
            wr_data = seq;
            if (push) exp_q.push_back(seq);
            seq = seq + 1'b1;
        end
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rclk);
            rd_en = 1'b1;
        end
        @(negedge rclk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge wclk);
        repeat (8) @(posedge rclk);
        @(negedge rclk);
    endtask

    task automatic clear_tide();
        @(negedge rclk);
        tide_clr = 1'b1;
        @(negedge rclk);
        tide_clr = 1'b0;
        settle();
    endtask

    task automatic do_reset(input int lg);
        @(negedge wclk);
        wrst = 1'b1; rrst = 1'b1;
        blk_lg = LW'(lg);
        repeat (4) @(posedge rclk);
        repeat (4) @(posedge wclk);
        @(negedge wclk); wrst = 1'b0;
        @(negedge rclk); rrst = 1'b0;
        exp_q.delete();
        settle();
    endtask

    initial begin
        do_reset(3);
        // R1 reset state
        chk("R1 wr_addr_rd", int'(wr_addr_rd), 0);
        chk("R1 rd_addr", int'(rd_addr), 0);
        chk("R1 lag_blks", int'(lag_blks), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 blk_event", int'(blk_event), 0);
        chk("R1 tide", int'(tide), 0);
        chk("R1 wr_stall", int'(wr_stall), 0);

        // one full block of 8 words
        evt_base = evt_cnt;
        write_n(8, 1'b1);
        settle();
        chk("R3 one event per block", evt_cnt - evt_base, 1);
        chk("R4 tide set", int'(tide), 1);
        chk("R5 write location", int'(wr_addr_rd), 8);
        chk("R6 lag one block", int'(lag_blks), 1);
        repeat (20) @(posedge rclk);
        @(negedge rclk);
        chk("R4 tide sticky", int'(tide), 1);
        clear_tide();
        chk("R4 tide cleared", int'(tide), 0);

        read_n(8);
        settle();
        chk("R2 read location", int'(rd_addr), 8);
        chk("R6 lag caught up", int'(lag_blks), 0);

        // partial block: no event
        evt_base = evt_cnt;
        write_n(7, 1'b1);
        settle();
        chk("R3 no event mid block", evt_cnt - evt_base, 0);
        chk("R4 tide stays clear", int'(tide), 0);
        chk("R5 write location 15", int'(wr_addr_rd), 15);
        chk("R6 lag partial", int'(lag_blks), 0);
        write_n(1, 1'b1);
        settle();
        chk("R3 event on boundary", evt_cnt - evt_base, 1);
        chk("R6 lag after boundary", int'(lag_blks), 1);
        clear_tide();

        // stall request
        @(negedge rclk);
        stall_req = 1'b1;
        settle();
        @(negedge wclk);
        chk("R7 stall raised", int'(wr_stall), 1);
        write_n(4, 1'b0);
        settle();
        chk("R7 writes ignored", int'(wr_addr_rd), 16);
        @(negedge rclk);
        stall_req = 1'b0;
        settle();
        @(negedge wclk);
        chk("R7 stall released", int'(wr_stall), 0);

        read_n(8);
        settle();
        chk("R2 read location 16", int'(rd_addr), 16);

        // wrap around the ring
        evt_base = evt_cnt;
        write_n(48, 1'b1);
        settle();
        chk("R8 write location wrapped", int'(wr_addr_rd), 0);
        chk("R3 six events", evt_cnt - evt_base, 6);
        chk("R8 lag across wrap", int'(lag_blks), 6);
        read_n(48);
        settle();
        chk("R8 read location wrapped", int'(rd_addr), 0);
        chk("R6 lag zero after drain", int'(lag_blks), 0);
        chk("R2 scoreboard drained", exp_q.size(), 0);

        // new block size under reset
        do_reset(4);
        chk("R1 reset after resize", int'(wr_addr_rd), 0);
        evt_base = evt_cnt;
        write_n(15, 1'b1);
        settle();
        chk("R9 no event at 15 words", evt_cnt - evt_base, 0);
        chk("R9 lag zero at 15 words", int'(lag_blks), 0);
        write_n(1, 1'b1);
        settle();
        chk("R9 event at 16 words", evt_cnt - evt_base, 1);
        chk("R9 lag one block", int'(lag_blks), 1);
        read_n(16);
        settle();
        chk("R2 scoreboard drained 2", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule